// File: doc/BRIEF.md
# Serial control-register packet decoder

This block is the device-side end of a bit-serial bus that configures control registers. The serial clock drives all of its logic. A framing pattern on the command input starts each transaction. The block then collects 16-bit packets from the serial data input, most significant bit first.

The first packet is the request. The block decodes three fields from it:
- a 4-bit opcode,
- a 6-bit device identifier,
- a broadcast flag.

A read or a write is four packets long. The request is followed by an address packet, an all-zero interval packet and a data packet. The block writes the data packet into a small register file, or it drives the addressed register back out on the serial output during the data packet.

Three other commands are a single request packet each:
- Set reset holds the register file at its reset values.
- Clear reset releases that hold.
- Set fast clock raises a mode flag for the surrounding clocking logic.

Several controllers' devices share the bus. The device-identifier compare and the broadcast flag decide whether this device acts on a request.

Top module: `ctl_serial_dec`

## Requirements
- R1: A transaction starts only while the decoder is idle, and only when `cmd_i` is sampled 1,1,1,1,0,0,0,0 on eight consecutive rising edges. Request bit 15 is sampled on the first rising edge after the edge that samples the last 0, and each later bit follows on the next edge. Any other pattern (for example three 1s) starts nothing.
- R2: Request packet bit positions (bit 15 is sent first):
  - bits 15..11 are zero,
  - bit 10 is device-ID bit 5,
  - bits 9..6 are the opcode,
  - bit 5 is the broadcast flag,
  - bits 4..0 are device-ID bits 4..0.

  The device acts only when the 6-bit ID equals `dev_id_i` or the broadcast flag is 1. Otherwise the request has no effect, and the output stays 0.
- R3: Opcodes are 0000 read, 0001 write, 0010 set reset, 0100 set fast clock, 1011 clear reset and 1111 no operation. No operation and all other codes change nothing, and they end the transaction after the request packet.
- R4: A read or a write is four packets: request, address, interval, data. The address is bits 11..0 of the second packet. The third packet is ignored. The data packet is sent most significant bit first.
- R5: A write to a selected device and an implemented address stores the data packet into that register when the data packet's last bit is sampled.
- R6: On a selected read, `sdo_o` carries bit 15-k of the addressed register during data-packet cycle k (k = 0..15). At every other time `sdo_o` is 0.
- R7: Implemented addresses are 0..NREGS-1 (NREGS = 8). A read of any other address returns 16 zero bits. A write to such an address changes no register.
- R8: A selected set reset sets `rst_held_o` on the edge that samples the last request bit. It also returns every register i to the reset value {8'h5A, i[7:0]}.
- R9: While `rst_held_o` is 1, every command except clear reset is ignored: reads drive 0, writes are dropped, and set fast clock does not change `fast_mode_o`.
- R10: A selected clear reset drops `rst_held_o` on the edge that samples the last request bit. The registers keep their reset values.
- R11: A selected set fast clock, issued while not held, sets `fast_mode_o`. Only `rst_n` clears it.
- R12: While `rst_n` is low the outputs and state are at reset: decoder idle, `sdo_o` 0, `fast_mode_o` 0, `rst_held_o` 0, every register at {8'h5A, i}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 1 | Framing input that starts a transaction |
| sdi_i | input | 1 | Serial packet data, MSB first |
| dev_id_i | input | 6 | This device's configured identifier |
| sdo_o | output | 1 | Serial read data during the data packet, else 0 |
| fast_mode_o | output | 1 | Fast clock mode flag |
| rst_held_o | output | 1 | Register file held in reset |

## Verification
Set reset, clear reset and set fast clock change the status outputs on the rising edge that samples request bit 0. The bench therefore checks those outputs at a falling edge after the request packet has been driven. Read bit 15-k appears in the half period before the edge that would sample data-packet bit k. The read task collects it at the falling edge that opens that cycle and hands the 16-bit word to a scoreboard that compares it with the modelled register. Outside that window a monitor checks `sdo_o` at every falling edge. Because of this, ignored reads, unselected devices and out-of-range addresses are all observed as an all-zero word at the port.

// File: rtl/ctl_serial_pkg.sv
package ctl_serial_pkg;

  localparam int PKT_BITS = 16;
  localparam int REG_W    = 16;
  localparam int ADDR_W   = 12;
  localparam int DEV_W    = 6;

  typedef enum logic [3:0] {
    OP_READ  = 4'b0000,
    OP_WRITE = 4'b0001,
    OP_SETR  = 4'b0010,
    OP_SETF  = 4'b0100,
    OP_CLRR  = 4'b1011,
    OP_NOP   = 4'b1111
  } ctl_op_e;

  // device identifier is split around the opcode inside the request word
  function automatic logic [DEV_W-1:0] req_dev(input logic [PKT_BITS-1:0] w);
    return {w[10], w[4:0]};
  endfunction

  function automatic logic [3:0] req_op(input logic [PKT_BITS-1:0] w);
    return w[9:6];
  endfunction

  function automatic logic req_bcast(input logic [PKT_BITS-1:0] w);
    return w[5];
  endfunction

  function automatic logic [ADDR_W-1:0] pkt_addr(input logic [PKT_BITS-1:0] w);
    return w[ADDR_W-1:0];
  endfunction

  function automatic logic [REG_W-1:0] reg_init(input int unsigned idx);
    return {8'h5A, 8'(idx)};
  endfunction

endpackage

// File: rtl/ctl_frame_det.sv
module ctl_frame_det #(
  parameter int HI_LEN = 4,
  parameter int LO_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_i,
  input  logic armed_i,
  output logic start_o
);
  localparam int LEN = HI_LEN + LO_LEN;
  localparam logic [LEN-1:0] PATTERN = {{HI_LEN{1'b1}}, {LO_LEN{1'b0}}};

  logic [LEN-2:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= {hist_q[LEN-3:0], cmd_i};
  end

  // the current sample completes the window, so the packet starts next edge
  assign start_o = armed_i && ({hist_q, cmd_i} == PATTERN);
endmodule

// File: rtl/ctl_pkt_seq.sv
module ctl_pkt_seq #(
  parameter int PKT_BITS = 16,
  parameter int NPKT     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic                        sdi_i,
  input  logic                        last_i,
  output logic                        busy_o,
  output logic [$clog2(NPKT)-1:0]     pkt_o,
  output logic [$clog2(PKT_BITS)-1:0] bit_o,
  output logic [PKT_BITS-1:0]         word_o,
  output logic                        done_o
);
  localparam int BW = $clog2(PKT_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(PKT_BITS - 1);

  logic [PKT_BITS-2:0] sh_q;

  assign word_o = {sh_q, sdi_i};
  assign done_o = busy_o && (bit_o == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      pkt_o  <= '0;
      bit_o  <= '0;
      sh_q   <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      pkt_o  <= '0;
      bit_o  <= '0;
    end else if (busy_o) begin
      sh_q <= word_o[PKT_BITS-2:0];
      if (done_o) begin
        bit_o <= '0;
        if (last_i) busy_o <= 1'b0;
        else        pkt_o  <= pkt_o + 1'b1;
      end else begin
        bit_o <= bit_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import ctl_serial_pkg::*;
#(
  parameter int NREGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              hit_o
);
  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [REG_W-1:0] regs [NREGS];

  assign hit_o = (addr_i < ADDR_W'(NREGS));

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        q <= reg_init(g);
      else if (clr_i)                                    q <= reg_init(g);
      else if (we_i && hit_o && addr_i[IW-1:0] == IW'(g)) q <= wdata_i;
    end
    assign regs[g] = q;
  end

  assign rdata_o = hit_o ? regs[addr_i[IW-1:0]] : '0;
endmodule

// File: rtl/ctl_serial_dec.sv
module ctl_serial_dec
  import ctl_serial_pkg::*;
#(
  parameter int NREGS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_i,
  input  logic             sdi_i,
  input  logic [DEV_W-1:0] dev_id_i,
  output logic             sdo_o,
  output logic             fast_mode_o,
  output logic             rst_held_o
);
  localparam int NPKT = 4;
  localparam int PW   = $clog2(NPKT);
  localparam int BW   = $clog2(PKT_BITS);
  localparam logic [PW-1:0] PK_REQ  = PW'(0);
  localparam logic [PW-1:0] PK_ADDR = PW'(1);
  localparam logic [PW-1:0] PK_GAP  = PW'(2);
  localparam logic [PW-1:0] PK_DATA = PW'(3);

  logic                start, busy, done, last;
  logic [PW-1:0]       pkt;
  logic [BW-1:0]       bitc;
  logic [PKT_BITS-1:0] word;

  logic [3:0] op;
  logic       sel, is_rw, req_done;
  logic       ev_setr, ev_clrr, ev_setf, ev_wr;

  logic              held_q, fast_q, act_q, rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REG_W-1:0]  rd_word_q, rf_rdata;
  logic              rf_hit;

  ctl_frame_det #(.HI_LEN(4), .LO_LEN(4)) u_frame (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .armed_i(!busy), .start_o(start)
  );

  ctl_pkt_seq #(.PKT_BITS(PKT_BITS), .NPKT(NPKT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sdi_i(sdi_i), .last_i(last),
    .busy_o(busy), .pkt_o(pkt), .bit_o(bitc), .word_o(word), .done_o(done)
  );

  ctl_regfile #(.NREGS(NREGS)) u_rf (
    .clk(clk), .rst_n(rst_n), .clr_i(ev_setr), .we_i(ev_wr), .addr_i(addr_q),
    .wdata_i(word), .rdata_o(rf_rdata), .hit_o(rf_hit)
  );

  // request decode on the cycle its last bit is sampled
  assign op       = req_op(word);
  assign sel      = req_bcast(word) || (req_dev(word) == dev_id_i);
  assign is_rw    = (op == OP_READ) || (op == OP_WRITE);
  assign req_done = done && (pkt == PK_REQ);
  assign last     = (pkt == PK_DATA) || ((pkt == PK_REQ) && !is_rw);

  // named events for the checker
  assign ev_setr = req_done && sel && (op == OP_SETR);
  assign ev_clrr = req_done && sel && (op == OP_CLRR);
  assign ev_setf = req_done && sel && (op == OP_SETF) && !held_q;
  assign ev_wr   = done && (pkt == PK_DATA) && act_q && !rd_q && rf_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q    <= 1'b0;
      fast_q    <= 1'b0;
      act_q     <= 1'b0;
      rd_q      <= 1'b0;
      addr_q    <= '0;
      rd_word_q <= '0;
    end else begin
      if (ev_setr)      held_q <= 1'b1;
      else if (ev_clrr) held_q <= 1'b0;
      if (ev_setf) fast_q <= 1'b1;
      if (req_done) begin
        act_q <= sel && is_rw && !held_q;
        rd_q  <= (op == OP_READ);
      end
      if (done && pkt == PK_ADDR) addr_q <= pkt_addr(word);
      if (done && pkt == PK_GAP)  rd_word_q <= (act_q && rd_q) ? rf_rdata : '0;
    end
  end

  assign sdo_o       = busy && (pkt == PK_DATA) && rd_word_q[~bitc];
  assign fast_mode_o = fast_q;
  assign rst_held_o  = held_q;
endmodule

// File: rtl/ctl_serial_dec_chk.sv
module ctl_serial_dec_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic sdo_o,
  input logic rst_held_o,
  input logic fast_mode_o,
  input logic ev_setr,
  input logic ev_clrr,
  input logic ev_setf,
  input logic ev_wr
);
  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sdo_o);

  // R9
  held_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |-> !rst_held_o);

  // R9
  held_no_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_held_o |-> !ev_setf);

  // R8
  setr_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_setr |=> rst_held_o);

  // R10
  clrr_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clrr |=> !rst_held_o);

  // R11
  fast_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_mode_o |=> fast_mode_o);

  // R3
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_setr, ev_clrr, ev_setf, ev_wr}));
endmodule

bind ctl_serial_dec ctl_serial_dec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .sdo_o(sdo_o),
  .rst_held_o(rst_held_o), .fast_mode_o(fast_mode_o), .ev_setr(ev_setr),
  .ev_clrr(ev_clrr), .ev_setf(ev_setf), .ev_wr(ev_wr)
);

// File: tb/ctl_serial_dec_tb.sv
module ctl_serial_dec_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] DEV   = 6'h2D;
  localparam logic [5:0] OTHER = 6'h0D;  // differs only in ID bit 5
  localparam logic [3:0] C_RD = 4'b0000, C_WR = 4'b0001, C_SETR = 4'b0010,
                         C_SETF = 4'b0100, C_CLRR = 4'b1011, C_NOP = 4'b1111;

  logic clk = 1'b0, rst_n = 1'b0, cmd = 1'b0, sdi = 1'b0;
  logic sdo, fast, held;
  int total = 0, bad = 0;
  bit rd_window = 1'b0;

  logic [15:0] exp_q[$];
  logic [15:0] obs_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_serial_dec u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .sdi_i(sdi), .dev_id_i(DEV),
    .sdo_o(sdo), .fast_mode_o(fast), .rst_held_o(held)
  );

  function automatic logic [15:0] req_word(logic [3:0] op, logic bc, logic [5:0] dev);
    return {5'b0, dev[5], op, bc, dev[4:0]};
  endfunction

  task automatic check(string rq, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk) begin cmd = 1'b0; sdi = 1'b0; end
  endtask

  task automatic frame(int highs);
    for (int i = 0; i < highs + 4; i++) @(negedge clk) begin
      cmd = (i < highs); sdi = 1'b0;
    end
  endtask

  task automatic send(logic [15:0] w);
    for (int b = 15; b >= 0; b--) @(negedge clk) sdi = w[b];
  endtask

  task automatic cmd1(logic [3:0] op, logic bc, logic [5:0] dev);
    frame(4); send(req_word(op, bc, dev)); idle(2);
  endtask

  task automatic wr(logic bc, logic [5:0] dev, logic [11:0] a, logic [15:0] d);
    frame(4); send(req_word(C_WR, bc, dev)); send({4'b0, a}); send(16'h0); send(d);
    idle(2);
  endtask

  // driver: pushes expected word, collects what the port carried
  task automatic rd(string rq, logic bc, logic [5:0] dev, logic [11:0] a,
                    logic [15:0] exp);
    logic [15:0] obs = '0;
    frame(4); send(req_word(C_RD, bc, dev)); send({4'b0, a}); send(16'h0);
    rd_window = 1'b1;
    for (int k = 0; k < 16; k++) @(negedge clk) begin obs[15-k] = sdo; sdi = 1'b0; end
    @(negedge clk) rd_window = 1'b0;
    exp_q.push_back(exp); tag_q.push_back(rq); obs_q.push_back(obs);
    idle(2);
  endtask

  // monitor: scoreboard pops and idle-output check
  initial forever @(negedge clk) begin
    if (rst_n && !rd_window) check("R6 sdo idle zero", {15'b0, sdo}, 16'h0);
    if (obs_q.size() > 0 && exp_q.size() > 0)
      check(tag_q.pop_front(), obs_q.pop_front(), exp_q.pop_front());
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    check("R12 held at reset", {15'b0, held}, 16'h0);
    check("R12 fast at reset", {15'b0, fast}, 16'h0);
    rst_n = 1'b1;
    idle(2);
    rd("R12 reset value reg3", 1'b0, DEV, 12'd3, 16'h5A03);
    wr(1'b0, DEV, 12'd2, 16'hBEEF);
    rd("R5 write then read reg2", 1'b0, DEV, 12'd2, 16'hBEEF);
    wr(1'b0, DEV, 12'd7, 16'h8001);
    rd("R4 last implemented reg7", 1'b0, DEV, 12'd7, 16'h8001);
    wr(1'b0, OTHER, 12'd2, 16'h1111);
    rd("R2 other-device write ignored", 1'b0, DEV, 12'd2, 16'hBEEF);
    rd("R2 other-device read silent", 1'b0, OTHER, 12'd2, 16'h0000);
    wr(1'b1, 6'h00, 12'd4, 16'h4444);
    rd("R2 broadcast write", 1'b0, DEV, 12'd4, 16'h4444);
    rd("R2 broadcast read", 1'b1, 6'h3F, 12'd4, 16'h4444);
    wr(1'b0, DEV, 12'd8, 16'hFFFF);
    rd("R7 out-of-range read", 1'b0, DEV, 12'd8, 16'h0000);
    rd("R7 no alias into reg0", 1'b0, DEV, 12'd0, 16'h5A00);
    rd("R7 far address read", 1'b0, DEV, 12'hFFF, 16'h0000);
    // three highs only: the write packets that follow must not start
    frame(3); send(req_word(C_WR, 1'b0, DEV)); send(16'd5); send(16'h0);
    send(16'h5555); idle(2);
    rd("R1 short frame ignored", 1'b0, DEV, 12'd5, 16'h5A05);
    cmd1(4'b0011, 1'b0, DEV);
    cmd1(4'b0110, 1'b1, DEV);
    check("R3 reserved op held", {15'b0, held}, 16'h0);
    check("R3 reserved op fast", {15'b0, fast}, 16'h0);
    rd("R3 decoder ready after reserved", 1'b0, DEV, 12'd2, 16'hBEEF);
    cmd1(C_SETR, 1'b0, OTHER);
    check("R2 set reset other device", {15'b0, held}, 16'h0);
    cmd1(C_SETR, 1'b0, DEV);
    check("R8 set reset holds", {15'b0, held}, 16'h1);
    rd("R9 read while held", 1'b0, DEV, 12'd2, 16'h0000);
    wr(1'b0, DEV, 12'd2, 16'h7777);
    cmd1(C_SETF, 1'b0, DEV);
    check("R9 fast clock while held", {15'b0, fast}, 16'h0);
    check("R9 still held", {15'b0, held}, 16'h1);
    cmd1(C_CLRR, 1'b0, DEV);
    check("R10 clear reset releases", {15'b0, held}, 16'h0);
    rd("R8 reg2 reset value, R9 write dropped", 1'b0, DEV, 12'd2, 16'h5A02);
    rd("R10 reg4 keeps reset value", 1'b0, DEV, 12'd4, 16'h5A04);
    rd("R8 reg7 reset value", 1'b0, DEV, 12'd7, 16'h5A07);
    cmd1(C_SETF, 1'b0, DEV);
    check("R11 fast clock set", {15'b0, fast}, 16'h1);
    cmd1(C_NOP, 1'b0, DEV);
    check("R3 nop keeps fast", {15'b0, fast}, 16'h1);
    check("R3 nop keeps held", {15'b0, held}, 16'h0);
    wr(1'b0, DEV, 12'd6, 16'h0F0F);
    rd("R11 R5 write in fast mode", 1'b0, DEV, 12'd6, 16'h0F0F);
    check("R11 fast stays", {15'b0, fast}, 16'h1);
    @(negedge clk) rst_n = 1'b0;
    idle(2);
    check("R12 fast cleared by reset", {15'b0, fast}, 16'h0);
    rst_n = 1'b1;
    idle(2);
    rd("R12 reg6 back to reset value", 1'b0, DEV, 12'd6, 16'h5A06);
    idle(4);
    check("R6 scoreboard drained", 16'(obs_q.size()), 16'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule